// File: doc/BRIEF.md
# Control-Register Write Interlock Detector

This block sits at the issue stage of a DSP pipeline. Every cycle it is shown one pre-decoded instruction (valid flag, opcode class, destination-register code) and decides whether that instruction may issue now or must be held. A held instruction stays at the stage input and `issue` stays low until the hold ends.

Two hazards are covered. A move-class write to the status register costs the following slot one extra cycle. A move-class write to the upper or lower word of the system stack costs three extra cycles to the instruction two slots later, but only when that instruction starts a loop, leaves a loop, returns, or breaks conditionally. The block keeps a short history of the slots that went past. Both an issued instruction and an empty slot count as a slot. When both hazards land on the same instruction, the longer hold wins.

Writes to other control registers have no effect on this block. That includes writes to the loop-end address, the loop count, the stack pointer, the stack counter and the operating mode. Instructions outside the move class have no effect whatever their destination code.

Top module: `ilk_flow_detect`

## Requirements
- R1: After a synchronous active-high reset, `stall` is 0 and the slot history is empty, so the first instruction after reset issues in the cycle it is shown.
- R2: Class codes 1 to 8 form the move class: plain, multi-register, peripheral and control moves, then bit set, bit clear, bit change and bit test. Only these record a write. Destination code 3 is the status register, 6 is the stack upper word and 7 is the stack lower word.
- R3: A valid instruction shown in the slot right after a move-class write to destination 3 holds `stall` high for exactly 1 cycle and then issues.
- R4: Class codes 9 to 14 are the stack-sensitive classes: loop start, loop start from register, interrupt return, subroutine return, loop exit and conditional break. One of these, shown two slots after a move-class write to destination 6 or 7, holds `stall` high for exactly 3 cycles and then issues.
- R5: The slot directly after a stack upper/lower write gets no stall from the stack rule. A non-sensitive class two slots later gets no stall either.
- R6: The following cause no stall: move-class writes to codes 1 (loop end), 2 (loop count), 4 (stack pointer), 5 (stack counter), 8 (operating mode) or any other code, and any class outside 1 to 8 whatever its destination.
- R7: When both rules apply to one instruction, it is held for the larger count, which is 3 cycles.
- R8: `issue` equals `in_valid` and not `stall`. `stall` is only high while `in_valid` is high, and the stall cycles for one instruction are contiguous and end in its issue.
- R9: An empty slot (`in_valid` low) never stalls, and it passes through the history as a non-write.
- R10: The history advances only in cycles with an issue or an empty slot, never in a stall cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is present at the issue stage |
| in_cls | input | 4 | Opcode class code |
| in_dst | input | 4 | Destination register code |
| stall | output | 1 | Hold the presented instruction this cycle |
| issue | output | 1 | The presented instruction issues this cycle |

## Verification
The stall decision depends only on the presented slot and on registered history, so `stall` and `issue` are due in the same cycle the instruction is shown. Each further held cycle follows from the hold counter at the next edges. The bench drives inputs on the falling edge and samples one nanosecond later, before the rising edge that acts on them. For an instruction that needs a hold of L cycles, it expects `stall` in the first L sampled cycles and `issue` in cycle L+1. Its history model is updated only after an issue or an empty slot, and it is compared against the design on every clock for both directed and random streams.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

   localparam int CLS_W = 4;
   localparam int DST_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CLS_OTHER       = 4'd0,
      CLS_XFER        = 4'd1,
      CLS_XFER_MULTI  = 4'd2,
      CLS_XFER_PERIPH = 4'd3,
      CLS_XFER_CTRL   = 4'd4,
      CLS_BIT_SET     = 4'd5,
      CLS_BIT_CLR     = 4'd6,
      CLS_BIT_CHG     = 4'd7,
      CLS_BIT_TEST    = 4'd8,
      CLS_LOOP_START  = 4'd9,
      CLS_LOOP_REG    = 4'd10,
      CLS_RET_INT     = 4'd11,
      CLS_RET_SUB     = 4'd12,
      CLS_LOOP_EXIT   = 4'd13,
      CLS_BREAK_COND  = 4'd14,
      CLS_BRANCH      = 4'd15
   } ilk_cls_e;

   typedef enum logic [DST_W-1:0] {
      DST_DATA     = 4'd0,
      DST_LOOP_END = 4'd1,
      DST_LOOP_CNT = 4'd2,
      DST_STATUS   = 4'd3,
      DST_STK_PTR  = 4'd4,
      DST_STK_CNT  = 4'd5,
      DST_STK_HI   = 4'd6,
      DST_STK_LO   = 4'd7,
      DST_OPMODE   = 4'd8
   } ilk_dst_e;

   typedef struct packed {
      logic sr_wr;
      logic stk_wr;
   } ilk_mark_t;

   localparam int MARK_W = $bits(ilk_mark_t);

endpackage

// File: rtl/ilk_classify.sv
module ilk_classify
   import ilk_pkg::*;
(
   input  logic             valid_i,
   input  logic [CLS_W-1:0] cls_i,
   input  logic [DST_W-1:0] dst_i,
   output ilk_mark_t        mark_o,
   output logic             stk_sens_o
);

   logic is_move;

   always_comb begin
      unique case (cls_i)
         CLS_XFER, CLS_XFER_MULTI, CLS_XFER_PERIPH, CLS_XFER_CTRL,
         CLS_BIT_SET, CLS_BIT_CLR, CLS_BIT_CHG, CLS_BIT_TEST: is_move = 1'b1;
         default:                                             is_move = 1'b0;
      endcase
   end

   always_comb begin
      unique case (cls_i)
         CLS_LOOP_START, CLS_LOOP_REG, CLS_RET_INT,
         CLS_RET_SUB, CLS_LOOP_EXIT, CLS_BREAK_COND: stk_sens_o = valid_i;
         default:                                    stk_sens_o = 1'b0;
      endcase
   end

   always_comb begin
      mark_o        = '0;
      mark_o.sr_wr  = valid_i && is_move && (dst_i == DST_STATUS);
      mark_o.stk_wr = valid_i && is_move &&
                      ((dst_i == DST_STK_HI) || (dst_i == DST_STK_LO));
   end

endmodule

// File: rtl/ilk_history.sv
module ilk_history #(
   parameter int DEPTH  = 2,
   parameter int WIDTH  = 2,
   parameter int TAP_A  = 1,
   parameter int TAP_B  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv_i,
   input  logic [WIDTH-1:0] push_i,
   output logic [WIDTH-1:0] tap_a_o,
   output logic [WIDTH-1:0] tap_b_o
);

   generate
      if (DEPTH < 1)                      $error("history depth must be at least 1");
      if (TAP_A < 1 || TAP_A > DEPTH)     $error("tap A outside history");
      if (TAP_B < 1 || TAP_B > DEPTH)     $error("tap B outside history");
      if (TAP_A != DEPTH && TAP_B != DEPTH) $error("deepest entry must be tapped");
   endgenerate

   logic [WIDTH-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst)        slot_q[0] <= '0;
      else if (adv_i) slot_q[0] <= push_i;
   end

   generate
      for (genvar g = 1; g < DEPTH; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst)        slot_q[g] <= '0;
            else if (adv_i) slot_q[g] <= slot_q[g-1];
         end
      end
   endgenerate

   assign tap_a_o = slot_q[TAP_A-1];
   assign tap_b_o = slot_q[TAP_B-1];

endmodule

// File: rtl/ilk_hazard_eval.sv
module ilk_hazard_eval
   import ilk_pkg::*;
#(
   parameter int SR_HOLD  = 1,
   parameter int STK_HOLD = 3,
   parameter int CNT_W    = 2
) (
   input  logic             valid_i,
   input  ilk_mark_t        near_i,
   input  ilk_mark_t        far_i,
   input  logic             stk_sens_i,
   output logic [CNT_W-1:0] len_o
);

   localparam logic [CNT_W-1:0] SR_LEN  = CNT_W'(SR_HOLD);
   localparam logic [CNT_W-1:0] STK_LEN = CNT_W'(STK_HOLD);

   logic [CNT_W-1:0] sr_len;
   logic [CNT_W-1:0] stk_len;

   always_comb begin
      sr_len  = (valid_i && near_i.sr_wr)               ? SR_LEN  : '0;
      stk_len = (valid_i && far_i.stk_wr && stk_sens_i) ? STK_LEN : '0;
      len_o   = (sr_len > stk_len) ? sr_len : stk_len;
   end

endmodule

// File: rtl/ilk_hold_timer.sv
module ilk_hold_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             stall_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             served_q;
   logic             start;

   assign start   = valid_i && !served_q && (cnt_q == '0) && (len_i != '0);
   assign stall_o = (cnt_q != '0) || start;
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         served_q <= 1'b0;
      end else if (cnt_q != '0) begin
         cnt_q    <= cnt_q - 1'b1;
      end else if (start) begin
         cnt_q    <= len_i - 1'b1;
         served_q <= 1'b1;
      end else begin
         served_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ilk_flow_detect.sv
module ilk_flow_detect
   import ilk_pkg::*;
#(
   parameter int SR_HOLD  = 1,
   parameter int STK_HOLD = 3,
   parameter int SR_DIST  = 1,
   parameter int STK_DIST = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [CLS_W-1:0] in_cls,
   input  logic [DST_W-1:0] in_dst,
   output logic             stall,
   output logic             issue
);

   localparam int HOLD_MAX   = (SR_HOLD > STK_HOLD) ? SR_HOLD : STK_HOLD;
   localparam int CNT_W      = $clog2(HOLD_MAX + 1);
   localparam int HIST_DEPTH = (SR_DIST > STK_DIST) ? SR_DIST : STK_DIST;

   generate
      if (SR_HOLD < 1 || STK_HOLD < 1) $error("hold lengths must be positive");
      if (SR_DIST < 1 || STK_DIST < 1) $error("hazard distances must be positive");
   endgenerate

   ilk_mark_t        push_mark;
   ilk_mark_t        near_mark;
   ilk_mark_t        far_mark;
   logic             stk_sens;
   logic [CNT_W-1:0] hold_len;
   logic [CNT_W-1:0] hold_cnt;
   logic             advance;

   ilk_classify u_classify (
      .valid_i    (in_valid),
      .cls_i      (in_cls),
      .dst_i      (in_dst),
      .mark_o     (push_mark),
      .stk_sens_o (stk_sens)
   );

   ilk_history #(
      .DEPTH (HIST_DEPTH),
      .WIDTH (MARK_W),
      .TAP_A (SR_DIST),
      .TAP_B (STK_DIST)
   ) u_history (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (advance),
      .push_i  (push_mark),
      .tap_a_o (near_mark),
      .tap_b_o (far_mark)
   );

   ilk_hazard_eval #(
      .SR_HOLD  (SR_HOLD),
      .STK_HOLD (STK_HOLD),
      .CNT_W    (CNT_W)
   ) u_hazard (
      .valid_i    (in_valid),
      .near_i     (near_mark),
      .far_i      (far_mark),
      .stk_sens_i (stk_sens),
      .len_o      (hold_len)
   );

   ilk_hold_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .valid_i (in_valid),
      .len_i   (hold_len),
      .stall_o (stall),
      .cnt_o   (hold_cnt)
   );

   assign issue   = in_valid && !stall;
   assign advance = !stall;

endmodule

// File: rtl/ilk_flow_detect_chk.sv
module ilk_flow_detect_chk #(
   parameter int CNT_W    = 2,
   parameter int HOLD_MAX = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             stall,
   input logic             issue,
   input logic             push_sr,
   input logic [1:0]       near_q,
   input logic [1:0]       far_q,
   input logic [CNT_W-1:0] cnt
);

   a_r8_no_issue_in_stall: assert property (@(posedge clk) disable iff (rst)
      stall |-> !issue);

   a_r8_valid_issues_or_stalls: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (issue || stall));

   a_r9_bubble_never_stalls: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> !stall);

   a_r10_history_frozen: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable({near_q, far_q}));

   a_r3_sr_write_holds_next: assert property (@(posedge clk) disable iff (rst)
      (issue && push_sr) |=> (in_valid |-> stall));

   a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
      int'(cnt) < HOLD_MAX);

endmodule

bind ilk_flow_detect ilk_flow_detect_chk #(
   .CNT_W    (CNT_W),
   .HOLD_MAX (HOLD_MAX)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .stall    (stall),
   .issue    (issue),
   .push_sr  (push_mark.sr_wr),
   .near_q   (near_mark),
   .far_q    (far_mark),
   .cnt      (hold_cnt)
);

// File: tb/ilk_flow_detect_bench.sv
module ilk_flow_detect_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [3:0] in_cls = 4'd0;
   logic [3:0] in_dst = 4'd0;
   logic       stall;
   logic       issue;

   int checks = 0;
   int fails  = 0;
   int hist[$];

   always #2 clk = ~clk;

   ilk_flow_detect u_ilk_flow_detect (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_cls   (in_cls),
      .in_dst   (in_dst),
      .stall    (stall),
      .issue    (issue)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int mark_of(input int v, input int c, input int d);
      if (v == 0 || c < 1 || c > 8) return 0;
      if (d == 3) return 1;
      if (d == 6 || d == 7) return 2;
      return 0;
   endfunction

   function automatic int hold_of(input int c);
      int a = (hist[0] == 1) ? 1 : 0;
      int b = (hist[1] == 2 && c >= 9 && c <= 14) ? 3 : 0;
      return (a > b) ? a : b;
   endfunction

   function automatic void push(input int m);
      hist.push_front(m);
      void'(hist.pop_back());
   endfunction

   task automatic slot(input int c, input int d, input string req);
      int len;
      @(negedge clk);
      in_valid = 1'b1;
      in_cls   = c[3:0];
      in_dst   = d[3:0];
      len = hold_of(c);
      for (int k = 0; k < len; k++) begin
         #1;
         check(stall === 1'b1 && issue === 1'b0, req, {stall, issue}, 2);
         @(negedge clk);
      end
      #1;
      check(stall === 1'b0 && issue === 1'b1, req, {stall, issue}, 1);
      push(mark_of(1, c, d));
   endtask

   task automatic bubble(input string req);
      @(negedge clk);
      in_valid = 1'b0;
      in_cls   = 4'd9;
      in_dst   = 4'd3;
      #1;
      check(stall === 1'b0 && issue === 1'b0, req, {stall, issue}, 0);
      push(0);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      hist = '{0, 0};
      repeat (3) @(posedge clk);
      #1;
      check(stall === 1'b0, "R1", stall, 0);
      @(negedge clk);
      rst = 1'b0;
      // R1: first instruction after reset, even a sensitive one
      slot(12, 0, "R1");
      // R3: each move class to the status register
      for (int c = 1; c <= 8; c++) begin
         slot(c, 3, "R2");
         slot(0, 0, "R3");
      end
      // R4: each stack-sensitive class two slots after upper/lower word writes
      for (int c = 9; c <= 14; c++) begin
         slot(1, (c % 2 == 0) ? 6 : 7, "R4");
         slot(0, 0, "R5");
         slot(c, 0, "R4");
      end
      // R5: sensitive instruction directly after a stack write
      slot(4, 6, "R5");
      slot(9, 0, "R5");
      slot(15, 0, "R5");
      // R6: excluded registers and non-move classes
      foreach (hist[i]) hist[i] = hist[i];
      slot(4, 1, "R6"); slot(4, 2, "R6"); slot(9, 0, "R6");
      slot(4, 4, "R6"); slot(4, 5, "R6"); slot(11, 0, "R6");
      slot(4, 8, "R6"); slot(0, 0, "R6"); slot(12, 0, "R6");
      slot(0, 3, "R6"); slot(15, 6, "R6"); slot(13, 0, "R6");
      // R7: both rules on one instruction
      slot(2, 7, "R7");
      slot(5, 3, "R7");
      slot(10, 0, "R7");
      // R9: bubble consumes slots
      slot(1, 3, "R9");
      bubble("R9");
      slot(0, 0, "R9");
      slot(1, 6, "R9");
      bubble("R9");
      slot(14, 0, "R9");
      // R10: long stall does not shift history
      slot(3, 6, "R10");
      slot(3, 3, "R10");
      slot(11, 0, "R10");
      slot(0, 0, "R10");
      // R8: random streams compared every clock
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom_range(0, 9);
         if (r == 0) bubble("R8");
         else slot($urandom_range(0, 15), $urandom_range(0, 9), "R8");
      end
      // R1: reset in the middle clears history
      slot(1, 6, "R1");
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      hist = '{0, 0};
      slot(0, 0, "R1");
      slot(9, 0, "R1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule